// File: doc/BRIEF.md
# Vectored Interrupt Priority Dispatcher

This block is the interrupt-ordering core of one processor. Sources raise requests by presenting an 8-bit vector, together with a bit that says whether the source is level- or edge-triggered. The block keeps one pending bit and one in-service bit for every vector. It offers the most urgent pending vector to the processor through a request/acknowledge handshake. A vector is urgent enough only when its priority class, which is the upper nibble of the vector, is above the class of the current processor priority.

Software sets a threshold through a task-priority register. The processor priority combines that threshold with the class of the highest vector now in service. When the handler finishes, software writes the end-of-interrupt register, and the highest in-service vector is retired. If that vector was level-triggered, a one-cycle completion pulse carrying the vector is sent out so that the source can re-arm.

Top module: `irq_dispatch`

## Requirements
- R1: After reset no request is offered (`intReq`=0), the task-priority register and the status register read 0, and `eoiBcast` is 0.
- R2: Of all pending vectors, the one with the largest numeric value is presented on `intVector`, provided its class passes the R3 gate.
- R3: `intReq` is 1 only when the class (bits 7:4) of the highest pending vector is strictly greater than the class of the processor priority. Raising the task-priority class therefore blocks lower vectors.
- R4: On a clock edge with `intReq` and `intAck` both 1, the presented vector leaves the pending set and enters the in-service set. The next vector is then offered only if it passes R3 against the new processor priority.
- R5: The processor priority (address 2, bits 7:0) equals the task-priority register when the task-priority class is at least the class of the highest in-service vector. Otherwise it is that in-service class in bits 7:4, with bits 3:0 zero.
- R6: A write to the end-of-interrupt address (1) clears only the highest in-service vector. Such a write with nothing in service changes nothing: the pending requests and the offered vector are left as they were.
- R7: When the retired vector was requested with `reqLevel`=1, `eoiBcast` is 1 for exactly the one cycle after the write edge, and `eoiVector` holds the retired vector. For an edge-triggered vector, `eoiBcast` stays 0.
- R8: A request for vectors 0x00–0x0F is dropped, never becomes pending, and sets bit 0 of the status register (address 3). That bit stays set until reset.
- R9: Address 0 holds the task-priority register. Bits 7:0 are writable, and bits 31:8 read as 0 whatever was written to them.
- R10: Repeated requests for a vector that is already pending merge into one pending bit, so a single acknowledge consumes them all.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe for one cycle |
| reqVector | input | 8 | Vector being requested |
| reqLevel | input | 1 | 1 = level-triggered source, 0 = edge |
| intReq | output | 1 | A vector is offered to the processor |
| intVector | output | 8 | Offered vector |
| intAck | input | 1 | Processor accepts the offered vector |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | 0 task priority, 1 end-of-interrupt, 2 processor priority, 3 status |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` |
| eoiBcast | output | 1 | Completion pulse for a retired level-triggered vector |
| eoiVector | output | 8 | Vector carried by the completion pulse |

## Verification
The bench targets the equal-class case. After a vector is acknowledged, a pending vector of the same class must be held back. A gate written as greater-or-equal would dispatch it at once, nested inside its own class. The bench also checks that a nested higher-class vector is retired first by the end-of-interrupt write: a design that cleared the lowest or the oldest in-service bit would leave the processor priority wrong. Further cases are an end-of-interrupt write while nothing is in service, which a careless design turns into a stray pulse or a dropped pending bit; illegal vectors, which must neither become pending nor let the sticky flag clear; and the pulse, which must last one cycle and appear only for level-triggered vectors.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] ADDR_TPR  = 2'd0;
  localparam logic [1:0] ADDR_EOI  = 2'd1;
  localparam logic [1:0] ADDR_PPR  = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  typedef struct packed {
    logic capture;
    logic illegal;
    logic dispatch;
    logic retire;
    logic tprWrite;
  } ctrlStrobes_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [VEC_W-1:0] reqVector,
  input  logic             reqLevel,
  input  logic [VEC_W-1:0] tprWrData,
  output logic [VEC_W-1:0] pendTop,
  output logic             pendAny,
  output logic [VEC_W-1:0] isrTop,
  output logic             isrAny,
  output logic [VEC_W-1:0] tprVal,
  output logic             illegalFlag,
  output logic             eoiBcast,
  output logic [VEC_W-1:0] eoiVector
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [NUM_VEC-1:0] pending;
  logic [NUM_VEC-1:0] inService;
  logic [NUM_VEC-1:0] trigLevel;

  // Highest set bit wins: later iterations overwrite earlier ones.
  always_comb begin
    pendTop = '0;
    pendAny = 1'b0;
    isrTop  = '0;
    isrAny  = 1'b0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (pending[i]) begin
        pendTop = VEC_W'(i);
        pendAny = 1'b1;
      end
      if (inService[i]) begin
        isrTop = VEC_W'(i);
        isrAny = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending     <= '0;
      inService   <= '0;
      trigLevel   <= '0;
      tprVal      <= '0;
      illegalFlag <= 1'b0;
      eoiBcast    <= 1'b0;
      eoiVector   <= '0;
    end else begin
      if (strb.dispatch) begin
        pending[pendTop]   <= 1'b0;
        inService[pendTop] <= 1'b1;
      end
      if (strb.capture) begin
        pending[reqVector]   <= 1'b1;
        trigLevel[reqVector] <= reqLevel;
      end
      if (strb.retire) begin
        inService[isrTop] <= 1'b0;
        eoiVector         <= isrTop;
      end
      if (strb.illegal)  illegalFlag <= 1'b1;
      if (strb.tprWrite) tprVal      <= tprWrData;
      eoiBcast <= strb.retire & trigLevel[isrTop];
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic               reqValid,
  input  logic [CLASS_W-1:0] reqClass,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic               intAck,
  input  logic [CLASS_W-1:0] pendClass,
  input  logic               pendAny,
  input  logic [CLASS_W-1:0] isrClass,
  input  logic               isrAny,
  input  logic [VEC_W-1:0]   tprVal,
  output ctrlStrobes_t       strb,
  output logic [VEC_W-1:0]   pprVal,
  output logic               intReq
);
  localparam int SUB_W = VEC_W - CLASS_W;

  logic [CLASS_W-1:0] activeClass;
  logic [CLASS_W-1:0] tprClass;

  assign activeClass = isrAny ? isrClass : '0;
  assign tprClass    = tprVal[VEC_W-1:SUB_W];

  always_comb begin
    if (tprClass >= activeClass) pprVal = tprVal;
    else                         pprVal = {activeClass, {SUB_W{1'b0}}};
  end

  assign intReq = pendAny && (pendClass > pprVal[VEC_W-1:SUB_W]);

  always_comb begin
    strb          = '0;
    strb.capture  = reqValid && (reqClass != '0);
    strb.illegal  = reqValid && (reqClass == '0);
    strb.dispatch = intReq && intAck;
    strb.retire   = regWrEn && (regAddr == ADDR_EOI) && isrAny;
    strb.tprWrite = regWrEn && (regAddr == ADDR_TPR);
  end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
  import irq_pkg::*;
#(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic              reqLevel,
  output logic              intReq,
  output logic [VEC_W-1:0]  intVector,
  input  logic              intAck,
  input  logic              regWrEn,
  input  logic [1:0]        regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              eoiBcast,
  output logic [VEC_W-1:0]  eoiVector
);
  localparam int SUB_W = VEC_W - CLASS_W;

  ctrlStrobes_t     strb;
  logic [VEC_W-1:0] pendTop;
  logic [VEC_W-1:0] isrTop;
  logic             pendAny;
  logic             isrAny;
  logic [VEC_W-1:0] tprVal;
  logic [VEC_W-1:0] pprVal;
  logic             illegalFlag;

  irq_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqVector(reqVector), .reqLevel(reqLevel),
    .tprWrData(regWrData[VEC_W-1:0]),
    .pendTop(pendTop), .pendAny(pendAny),
    .isrTop(isrTop), .isrAny(isrAny),
    .tprVal(tprVal), .illegalFlag(illegalFlag),
    .eoiBcast(eoiBcast), .eoiVector(eoiVector)
  );

  irq_control #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_ctl (
    .reqValid(reqValid), .reqClass(reqVector[VEC_W-1:SUB_W]),
    .regWrEn(regWrEn), .regAddr(regAddr), .intAck(intAck),
    .pendClass(pendTop[VEC_W-1:SUB_W]), .pendAny(pendAny),
    .isrClass(isrTop[VEC_W-1:SUB_W]), .isrAny(isrAny),
    .tprVal(tprVal), .strb(strb), .pprVal(pprVal), .intReq(intReq)
  );

  assign intVector = pendTop;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_TPR:  regRdData[VEC_W-1:0] = tprVal;
      ADDR_PPR:  regRdData[VEC_W-1:0] = pprVal;
      ADDR_STAT: regRdData[0]         = illegalFlag;
      default:   regRdData            = '0;
    endcase
  end
endmodule

// File: rtl/irq_dispatch_checker.sv
module irq_dispatch_checker #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              intReq,
  input logic [VEC_W-1:0]  intVector,
  input logic              intAck,
  input logic              regWrEn,
  input logic [1:0]        regAddr,
  input logic [DATA_W-1:0] regRdData,
  input logic              eoiBcast,
  input logic [VEC_W-1:0]  pprVal,
  input logic [VEC_W-1:0]  tprVal,
  input logic              illegalFlag
);
  localparam int SUB_W = VEC_W - CLASS_W;

  assert_no_class0_R8: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (intVector[VEC_W-1:SUB_W] != '0));

  assert_sticky_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegalFlag |=> illegalFlag);

  assert_ppr_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    pprVal[VEC_W-1:SUB_W] >= tprVal[VEC_W-1:SUB_W]);

  assert_ack_moves_R4: assert property (@(posedge clk) disable iff (!rstN)
    (intReq && intAck) |=> !(intReq && (intVector == $past(intVector))));

  assert_bcast_cause_R7: assert property (@(posedge clk) disable iff (!rstN)
    eoiBcast |-> $past(regWrEn && (regAddr == 2'd1)));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd0) |-> (regRdData[DATA_W-1:VEC_W] == '0));
endmodule

bind irq_dispatch irq_dispatch_checker #(.VEC_W(VEC_W), .CLASS_W(CLASS_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .intReq(intReq), .intVector(intVector), .intAck(intAck),
  .regWrEn(regWrEn), .regAddr(regAddr), .regRdData(regRdData), .eoiBcast(eoiBcast),
  .pprVal(pprVal), .tprVal(tprVal), .illegalFlag(illegalFlag)
);

// File: tb/sim_irq_dispatch.sv
module sim_irq_dispatch;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqVector = '0;
  logic        reqLevel = 1'b0;
  logic        intReq;
  logic [7:0]  intVector;
  logic        intAck = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        eoiBcast;
  logic [7:0]  eoiVector;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_dispatch u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector),
    .reqLevel(reqLevel), .intReq(intReq), .intVector(intVector), .intAck(intAck),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .eoiBcast(eoiBcast), .eoiVector(eoiVector)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic raise(input logic [7:0] v, input logic lvl);
    @(negedge clk);
    reqValid = 1'b1; reqVector = v; reqLevel = lvl;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic ackOne();
    @(negedge clk);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    chkEq("R1 intReq", intReq, 0);
    chkEq("R1 eoiBcast", eoiBcast, 0);
    rdReg(2'd0, d); chkEq("R1 tpr", d, 0);
    rdReg(2'd3, d); chkEq("R1 status", d, 0);
  endtask

  task automatic testPriority();
    logic [31:0] d;
    raise(8'h35, 0); raise(8'h3A, 0); raise(8'h21, 0);
    chkEq("R2 intReq", intReq, 1);
    chkEq("R2 top vector", intVector, 8'h3A);
    ackOne();
    chkEq("R3 same class held", intReq, 0);
    rdReg(2'd2, d); chkEq("R5 ppr from isr", d, 32'h30);
    wrReg(2'd1, 0);
    chkEq("R7 edge no pulse", eoiBcast, 0);
    chkEq("R6 retire frees next", intVector, 8'h35);
    chkEq("R6 intReq after retire", intReq, 1);
    ackOne(); wrReg(2'd1, 0);
    chkEq("R4 next lower", intVector, 8'h21);
    ackOne(); wrReg(2'd1, 0);
    chkEq("R4 all drained", intReq, 0);
  endtask

  task automatic testTaskPriority();
    logic [31:0] d;
    wrReg(2'd0, 32'hFFFF_FF5F);
    rdReg(2'd0, d); chkEq("R9 reserved bits zero", d, 32'h5F);
    rdReg(2'd2, d); chkEq("R5 ppr equals tpr", d, 32'h5F);
    raise(8'h52, 0);
    chkEq("R3 masked by tpr", intReq, 0);
    raise(8'h61, 0);
    chkEq("R3 above tpr", intReq, 1);
    chkEq("R3 above tpr vector", intVector, 8'h61);
    wrReg(2'd0, 0);
    ackOne();
    rdReg(2'd2, d); chkEq("R5 isr class over tpr", d, 32'h60);
    wrReg(2'd1, 0);
    chkEq("R3 unmasked vector", intVector, 8'h52);
    chkEq("R3 unmasked req", intReq, 1);
    ackOne(); wrReg(2'd1, 0);
  endtask

  task automatic testLevelEoi();
    raise(8'h90, 1);
    ackOne();
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd1;
    @(negedge clk);
    regWrEn = 1'b0;
    chkEq("R7 pulse high", eoiBcast, 1);
    chkEq("R7 pulse vector", eoiVector, 8'h90);
    @(negedge clk);
    chkEq("R7 pulse one cycle", eoiBcast, 0);
  endtask

  task automatic testEmptyEoi();
    wrReg(2'd1, 0);
    chkEq("R6 empty eoi no pulse", eoiBcast, 0);
    raise(8'h40, 0);
    wrReg(2'd1, 0);
    chkEq("R6 pending kept req", intReq, 1);
    chkEq("R6 pending kept vector", intVector, 8'h40);
    ackOne(); wrReg(2'd1, 0);
    chkEq("R6 drained", intReq, 0);
  endtask

  task automatic testIllegal();
    logic [31:0] d;
    raise(8'h0F, 0);
    chkEq("R8 not offered", intReq, 0);
    rdReg(2'd3, d); chkEq("R8 flag set", d, 1);
    raise(8'h33, 0);
    rdReg(2'd3, d); chkEq("R8 flag sticky", d, 1);
    ackOne(); wrReg(2'd1, 0);
  endtask

  task automatic testMerge();
    raise(8'h77, 0); raise(8'h77, 0);
    chkEq("R10 offered", intVector, 8'h77);
    ackOne();
    wrReg(2'd1, 0);
    chkEq("R10 single bit", intReq, 0);
  endtask

  task automatic testNested();
    logic [31:0] d;
    raise(8'h44, 0); ackOne();
    raise(8'h88, 0);
    chkEq("R3 nested higher", intReq, 1);
    chkEq("R3 nested vector", intVector, 8'h88);
    ackOne();
    rdReg(2'd2, d); chkEq("R5 nested ppr", d, 32'h80);
    wrReg(2'd1, 0);
    rdReg(2'd2, d); chkEq("R6 highest retired first", d, 32'h40);
    wrReg(2'd1, 0);
    rdReg(2'd2, d); chkEq("R6 all retired", d, 32'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPriority();
    testTaskPriority();
    testLevelEoi();
    testEmptyEoi();
    testIllegal();
    testMerge();
    testNested();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule